// File: doc/BRIEF.md
# Pin-Controlled Power-Down Hold Unit

This block sits between a group of package pins and the logic behind them. It controls entry into and exit from a low-activity hold state. A configuration bit arms the feature. Once armed, two pins of the group act as dedicated power-down requests. While either request reads high, the block freezes everything it presents: the internal logic signals, the sampled pin levels, and the values and enables of the outputs. Pin activity on the other pins has no effect until the request falls.

Each pin also has a keeper. A pin that nobody drives reads back the last level it was driven to. The request pins are seen through their keepers as well, so a request that is driven high and then left floating keeps the block held. A separate abort input, raised when a configuration load is cut short, turns off every output driver in the same cycle.

All presented values are registered. In normal running they follow their sources with one clock of latency. On release they take fresh values at the first clock edge after the request drops. They do not pass through any intermediate value on the way.

Top module: `pd_hold_unit`

## Requirements
- R1: With rst_n low at a rising clock edge, sig_q, pin_rd, pad_val, pad_oe and pd_active are all zero after that edge, and every keeper reads 0.
- R2: When no hold is in effect, sig_q, pin_rd, pad_val and pad_oe equal the values of core_sig, the resolved pin levels, out_val and out_en at the previous rising edge.
- R3: With pd_en high, if the resolved level of pin 0 or of pin 1 is high at a rising edge, pd_active is 1 after that edge and the presented values do not update at it.
- R4: With pd_en low, pd_active stays 0 and pins 0 and 1 behave as ordinary logic pins whatever their levels.
- R5: While pd_active is 1, sig_q and pad_val keep the values they had when the hold began.
- R6: While held, changes on pin_in, pin_drv, out_val, out_en and core_sig do not reach pin_rd or any other output.
- R7: At the first rising edge where neither request level is high, pd_active returns to 0 and all presented values load the current inputs.
- R8: An output whose enable was 0 when the hold began keeps pad_oe at 0 for the whole hold, even if out_en rises.
- R9: With pd_en high, pin_rd and pad_oe read 0 at bit positions 0 and 1, the request pins.
- R10: A pin with pin_drv 0 resolves to the level it last had while pin_drv was 1 (0 if never driven since reset).
- R11: While prog_abort is 1, pad_oe is all zeros in the same cycle; when it falls, the registered enables return.
- R12: A request pin driven high and then left undriven keeps the hold in effect until it is driven low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| pd_en | input | 1 | Configuration bit arming the power-down feature |
| prog_abort | input | 1 | Interrupted-configuration flag, forces all outputs off |
| core_sig | input | NSIG | Live internal logic signals |
| pin_in | input | NPIN | Raw level seen at each pin |
| pin_drv | input | NPIN | 1 where the pin is actively driven from outside |
| out_val | input | NPIN | Output value from the logic for each pin |
| out_en | input | NPIN | Output enable from the logic for each pin |
| sig_q | output | NSIG | Presented (held when frozen) internal signals |
| pin_rd | output | NPIN | Presented pin levels after keeper and hold |
| pad_val | output | NPIN | Value driven to each pin |
| pad_oe | output | NPIN | Driver enable for each pin |
| pd_active | output | 1 | 1 while the hold is in effect |

## Verification
On every cycle the assertions check the following. The presented values follow their sources with one cycle of latency outside a hold, and are frozen inside one. A disarmed block never holds. An enable that was off at hold entry never turns on during the hold. An undriven keeper never changes level, and a floating request keeps the hold alive. Some behaviour needs the bench's directed scenarios instead. These are which request pin starts a hold, the release timing, the masking of the two request pins and the same-cycle effect of the abort flag. They also include a reset arriving in the middle of a run.

// File: rtl/pdh_pkg.sv
// Package: shared types for the power-down hold unit.
// Assumes nothing beyond IEEE 1800-2017.
package pdh_pkg;
    typedef enum logic {
        PDH_RUN  = 1'b0,
        PDH_HOLD = 1'b1
    } pdh_state_e;
endpackage

// File: rtl/pdh_keeper.sv
// Module: pdh_keeper
// Resolves each pin to a logic level. A driven pin reads its raw level,
// an undriven pin reads the last level it was driven to.
// Assumes pin_drv is a clean per-pin flag sampled on clk.
module pdh_keeper #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_in,
    input  logic [W-1:0] pin_drv,
    output logic [W-1:0] lvl
);
    logic [W-1:0] keep_q;

    // Remember the level of every pin that is being driven.
    always_ff @(posedge clk) begin
        if (!rst_n) keep_q <= '0;
        else        keep_q <= (pin_drv & pin_in) | (~pin_drv & keep_q);
    end

    // Driven pins pass through, floating pins report the stored level.
    always_comb lvl = (pin_drv & pin_in) | (~pin_drv & keep_q);

    // R10
    keeper_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((~pin_drv & (lvl ^ $past(lvl))) == '0));
endmodule

// File: rtl/pdh_freeze.sv
// Module: pdh_freeze
// Register bank that loads its input every clock unless told to hold.
// Assumes hold is a registered-domain signal valid at the rising edge.
module pdh_freeze #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Capture the source value when not frozen.
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= '0;
        else if (!hold) q <= d;
    end
endmodule

// File: rtl/pd_hold_unit.sv
// Module: pd_hold_unit
// Power-down hold control for a pin group. Pins REQ_A and REQ_B are the
// request pins when pd_en is set; either one high freezes all presented
// signals, pin levels and output state. Keepers resolve floating pins.
// Assumes pd_en is a static configuration bit, changed only with care.
module pd_hold_unit
    import pdh_pkg::*;
#(
    parameter int NSIG  = 16,
    parameter int NPIN  = 8,
    parameter int REQ_A = 0,
    parameter int REQ_B = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pd_en,
    input  logic            prog_abort,
    input  logic [NSIG-1:0] core_sig,
    input  logic [NPIN-1:0] pin_in,
    input  logic [NPIN-1:0] pin_drv,
    input  logic [NPIN-1:0] out_val,
    input  logic [NPIN-1:0] out_en,
    output logic [NSIG-1:0] sig_q,
    output logic [NPIN-1:0] pin_rd,
    output logic [NPIN-1:0] pad_val,
    output logic [NPIN-1:0] pad_oe,
    output logic            pd_active
);
    localparam int PACK_W = 3 * NPIN;

    logic [NPIN-1:0]   lvl;
    logic [NPIN-1:0]   role_mask;
    logic              pd_now;
    pdh_state_e        state;
    logic [PACK_W-1:0] pin_pack_d;
    logic [PACK_W-1:0] pin_pack_q;
    logic [NPIN-1:0]   pin_h;
    logic [NPIN-1:0]   oe_h;

    // Pin keepers for the whole group, including the request pins.
    pdh_keeper #(.W(NPIN)) u_keep (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_drv(pin_drv), .lvl(lvl)
    );

    // Request pins give up their logic role when the feature is armed.
    for (genvar i = 0; i < NPIN; i++) begin : g_mask
        assign role_mask[i] = pd_en && ((i == REQ_A) || (i == REQ_B));
    end

    // Either request level high starts or prolongs the hold.
    always_comb pd_now = pd_en && (lvl[REQ_A] || lvl[REQ_B]);

    // Track the hold state; the hold ends on the first clear edge.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= PDH_RUN;
        else        state <= pd_now ? PDH_HOLD : PDH_RUN;
    end

    // Internal signals frozen while held.
    pdh_freeze #(.W(NSIG)) u_sig (
        .clk(clk), .rst_n(rst_n), .hold(pd_now), .d(core_sig), .q(sig_q)
    );

    // Pin levels, output values and enables frozen together.
    always_comb pin_pack_d = {oe_d_of(out_en), out_val, lvl};

    pdh_freeze #(.W(PACK_W)) u_pin (
        .clk(clk), .rst_n(rst_n), .hold(pd_now), .d(pin_pack_d), .q(pin_pack_q)
    );

    function automatic logic [NPIN-1:0] oe_d_of(input logic [NPIN-1:0] e);
        return e;
    endfunction

    // Unpack frozen state and apply pin-role masking and abort override.
    always_comb begin
        pin_h     = pin_pack_q[NPIN-1:0];
        pad_val   = pin_pack_q[2*NPIN-1:NPIN];
        oe_h      = pin_pack_q[PACK_W-1:2*NPIN];
        pin_rd    = pin_h & ~role_mask;
        pad_oe    = prog_abort ? '0 : (oe_h & ~role_mask);
        pd_active = (state == PDH_HOLD);
    end

    // R2
    follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(pd_now)) |-> (sig_q == $past(core_sig)));

    // R5
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pd_active |-> ($stable(sig_q) && $stable(pad_val)));

    // R4
    disarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_en |=> !pd_active);

    // R8
    oe_stay_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_active && $past(pd_active) && $past(rst_n) && !$past(prog_abort)
         && $stable(pd_en)) |-> ((pad_oe & ~$past(pad_oe)) == '0));

    // R12
    float_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_active && pd_en && !pin_drv[REQ_A] && !pin_drv[REQ_B]) |=> pd_active);
endmodule

// File: tb/pd_hold_unit_test.sv
`timescale 1ns/1ps
module pd_hold_unit_test;
    localparam int NSIG = 16;
    localparam int NPIN = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            pd_en = 1'b0;
    logic            prog_abort = 1'b0;
    logic [NSIG-1:0] core_sig = '0;
    logic [NPIN-1:0] pin_in = '0;
    logic [NPIN-1:0] pin_drv = '0;
    logic [NPIN-1:0] out_val = '0;
    logic [NPIN-1:0] out_en = '0;
    logic [NSIG-1:0] sig_q;
    logic [NPIN-1:0] pin_rd, pad_val, pad_oe;
    logic            pd_active;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #2.5 clk = ~clk;

    pd_hold_unit uut (
        .clk(clk), .rst_n(rst_n), .pd_en(pd_en), .prog_abort(prog_abort),
        .core_sig(core_sig), .pin_in(pin_in), .pin_drv(pin_drv),
        .out_val(out_val), .out_en(out_en), .sig_q(sig_q), .pin_rd(pin_rd),
        .pad_val(pad_val), .pad_oe(pad_oe), .pd_active(pd_active)
    );

    // Reference model state
    logic [NPIN-1:0] m_keep = '0;
    logic [NSIG-1:0] m_sig  = '0;
    logic [NPIN-1:0] m_pin  = '0, m_val = '0, m_oe = '0;
    logic            m_pd   = 1'b0;

    always @(posedge clk) begin
        logic [NPIN-1:0] lv;
        bit req;
        for (int i = 0; i < NPIN; i++) lv[i] = pin_drv[i] ? pin_in[i] : m_keep[i];
        req = pd_en && (lv[0] == 1'b1 || lv[1] == 1'b1);
        if (!rst_n) begin
            m_keep = '0; m_sig = '0; m_pin = '0; m_val = '0; m_oe = '0; m_pd = 0;
        end else begin
            for (int i = 0; i < NPIN; i++) if (pin_drv[i]) m_keep[i] = pin_in[i];
            if (!req) begin
                m_sig = core_sig; m_pin = lv; m_val = out_val; m_oe = out_en;
            end
            m_pd = req;
        end
    end

    task automatic cmp(string tag, string nm, logic [31:0] a, logic [31:0] e);
        n_tests++;
        if (a !== e) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, nm, a, e, $time);
        end
    endtask

    task automatic chk(string tag);
        logic [NPIN-1:0] mask;
        logic [NPIN-1:0] eoe;
        mask = pd_en ? 8'h03 : 8'h00;
        eoe  = prog_abort ? 8'h00 : (m_oe & ~mask);
        cmp(tag, "sig_q",     32'(sig_q),     32'(m_sig));
        cmp(tag, "pin_rd",    32'(pin_rd),    32'(m_pin & ~mask));
        cmp(tag, "pad_val",   32'(pad_val),   32'(m_val));
        cmp(tag, "pad_oe",    32'(pad_oe),    32'(eoe));
        cmp(tag, "pd_active", 32'(pd_active), 32'(m_pd));
    endtask

    task automatic tick(string tag);
        @(posedge clk);
        @(negedge clk);
        chk(tag);
    endtask

    task automatic shake_inputs(logic [NPIN-1:0] keep_bits, logic [NPIN-1:0] keep_val);
        core_sig = NSIG'($urandom);
        out_val  = NPIN'($urandom);
        out_en   = NPIN'($urandom);
        pin_in   = (NPIN'($urandom) & ~keep_bits) | (keep_val & keep_bits);
    endtask

    initial begin
        // R1: reset state
        tick("R1"); tick("R1");
        cmp("R1", "sig_q_rst", 32'(sig_q), 0);
        cmp("R1", "pd_rst", 32'(pd_active), 0);
        rst_n = 1'b1;

        // R2 / R9: normal running, request pins held low, feature armed
        pd_en = 1'b1; pin_drv = 8'hFF;
        for (int k = 0; k < 20; k++) begin
            shake_inputs(8'h03, 8'h00);
            tick("R2");
        end
        pin_in = 8'hFC; out_en = 8'hFF; tick("R9");
        cmp("R9", "pin_rd_mask", 32'(pin_rd), 32'h00FC);
        cmp("R9", "pad_oe_mask", 32'(pad_oe), 32'h00FC);

        // R4: disarmed, request pins are plain logic
        pd_en = 1'b0;
        for (int k = 0; k < 10; k++) begin
            shake_inputs(8'h03, 8'h03);
            tick("R4");
        end
        cmp("R4", "pd_off", 32'(pd_active), 0);
        cmp("R4", "pin01", 32'(pin_rd[1:0]), 32'h3);

        // R3 / R5 / R6: hold via request pin 0
        pd_en = 1'b1; shake_inputs(8'h03, 8'h00); tick("R2");
        shake_inputs(8'h03, 8'h01); tick("R3");
        cmp("R3", "pd_on_a", 32'(pd_active), 1);
        for (int k = 0; k < 8; k++) begin
            shake_inputs(8'h03, 8'h01); pin_drv = 8'h03 | NPIN'($urandom);
            tick("R6");
        end
        pin_drv = 8'hFF;
        // R7: release
        shake_inputs(8'h03, 8'h00); tick("R7");
        cmp("R7", "pd_off", 32'(pd_active), 0);
        cmp("R7", "fresh", 32'(sig_q), 32'(core_sig));

        // R8: enables off at entry stay off; hold via pin 1
        out_en = 8'h0F; pin_in = 8'h00; tick("R2");
        pin_in = 8'h02; out_en = 8'hFF; tick("R8");
        for (int k = 0; k < 5; k++) begin
            out_en = 8'hFF; out_val = NPIN'($urandom); tick("R8");
        end
        cmp("R8", "oe_held", 32'(pad_oe), 32'h0C);
        cmp("R3", "pd_on_b", 32'(pd_active), 1);
        pin_in = 8'h00; tick("R7");

        // R10: keeper on pin 5
        pin_in = 8'h20; tick("R10");
        pin_drv = 8'hDF; pin_in = 8'h00; tick("R10"); tick("R10");
        cmp("R10", "kept_hi", 32'(pin_rd[5]), 1);
        pin_drv = 8'hFF; pin_in = 8'h00; tick("R10");
        pin_drv = 8'hDF; pin_in = 8'h20; tick("R10"); tick("R10");
        cmp("R10", "kept_lo", 32'(pin_rd[5]), 0);
        pin_drv = 8'hFF;

        // R12: floating request keeps the hold
        pin_in = 8'h01; tick("R12");
        pin_drv = 8'hFE; pin_in = 8'h00;
        for (int k = 0; k < 4; k++) begin
            core_sig = NSIG'($urandom); tick("R12");
        end
        cmp("R12", "still_held", 32'(pd_active), 1);
        pin_drv = 8'hFF; pin_in = 8'h00; tick("R7");
        cmp("R12", "released", 32'(pd_active), 0);

        // R11: aborted configuration tri-states all drivers
        out_en = 8'hFF; tick("R2");
        prog_abort = 1'b1; #1;
        cmp("R11", "oe_abort", 32'(pad_oe), 0);
        tick("R11"); tick("R11");
        prog_abort = 1'b0; tick("R11");
        cmp("R11", "oe_back", 32'(pad_oe), 32'hFC);

        // Mixed traffic with occasional requests
        for (int k = 0; k < 300; k++) begin
            shake_inputs(8'h03, (($urandom % 6) == 0) ? NPIN'($urandom % 4) : 8'h00);
            pin_drv = (($urandom % 4) == 0) ? NPIN'($urandom) : 8'hFF;
            prog_abort = (($urandom % 16) == 0);
            tick("R5");
        end
        prog_abort = 1'b0;

        // R1: reset in the middle of a hold
        pin_drv = 8'hFF; pin_in = 8'h01; tick("R3");
        rst_n = 1'b0; tick("R1");
        cmp("R1", "pd_mid_rst", 32'(pd_active), 0);
        rst_n = 1'b1; pin_in = 8'h00; tick("R1");

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule